// File: doc/BRIEF.md
# PCI Configuration Cycle Router

This block sits between the processor's I/O request path and the configuration targets of a host bridge. It holds the configuration address latch at the address port (byte address 0CF8h) and watches the data window (byte address 0CFCh). Every access to the window while the latch is enabled becomes one configuration cycle. The cycle carries the decoded bus, device, function and register fields, the byte enables, the direction and the write data. It also carries a target code and a Type 0/Type 1 flag.

The target is chosen by the bus number. On bus 0, a fixed set of devices is internal and all other devices go to the hub link as Type 0 cycles. A bus number other than 0 is compared with the secondary and subordinate bus numbers of the AGP/PCI bridge. Read data returns to the processor through a registered path, with the byte lanes masked. The hub link engine, the AGP engine and the register file that answer the cycle are outside this block. While a cycle is out, the selected target drives `tgt_rdata`.

The I/O address is given as a DWord index (byte address bits 15:2), and `io_be` picks the bytes. Target codes are 0 for internal, 1 for hub link and 2 for AGP.

Top module: `cfg_cycle_router`

## Requirements
- R1: A write with all four byte enables set, to DWord index 0x33E (byte address 0CF8h), loads the address latch. A later read at that index returns bit 31 and bits 23:2 as written, with bits 30:24 and 1:0 as zero. A write with any byte enable clear leaves the latch unchanged.
- R2: While latch bit 31 is 0, a write to the data window (index 0x33F) produces no configuration cycle. A read of the window returns 0xFF on each enabled byte lane and 0x00 on the others.
- R3: While latch bit 31 is 1, each data-window access raises `cyc_valid` for exactly one clock, one clock after the request. The cycle carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and register = bits 7:2 of the latch, together with the request's byte enables, direction and write data.
- R4: Bus 0 with device 0, 1 or 6 selects target 0 (internal) with Type 0.
- R5: Bus 0 with any other device selects target 1 (hub link) with Type 0.
- R6: A non-zero bus equal to the secondary bus number selects target 2 (AGP) with Type 0.
- R7: A bus above the secondary bus number and not above the subordinate bus number selects target 2 (AGP) with Type 1.
- R8: A non-zero bus below the secondary bus number, or above the subordinate bus number, selects target 1 (hub link) with Type 1.
- R9: Every read at the address port or at the data window pulses `io_rvalid` two clocks after the request. For an enabled data-window read, `io_rdata` is `tgt_rdata` as sampled in the cycle's clock, with the bytes that are not enabled set to zero.
- R10: A request at any other index produces no cycle and no read response, and it leaves the address latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_req | input | 1 | I/O request strobe, one clock per access |
| io_addr | input | 14 | DWord index of the I/O address (byte address bits 15:2) |
| io_be | input | 4 | Byte enables |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_wdata | input | 32 | Write data |
| sec_bus | input | 8 | Bridge secondary bus number |
| sub_bus | input | 8 | Bridge subordinate bus number |
| tgt_rdata | input | 32 | Read data from the selected target during a cycle |
| cyc_valid | output | 1 | Configuration cycle strobe |
| cyc_tgt | output | 2 | Target: 0 internal, 1 hub link, 2 AGP |
| cyc_type1 | output | 1 | 1 = Type 1 cycle |
| cyc_bus | output | 8 | Bus number |
| cyc_dev | output | 5 | Device number |
| cyc_fn | output | 3 | Function number |
| cyc_reg | output | 6 | DWord register index |
| cyc_be | output | 4 | Byte enables of the cycle |
| cyc_wr | output | 1 | Direction of the cycle |
| cyc_wdata | output | 32 | Write data of the cycle |
| io_rvalid | output | 1 | Read response strobe |
| io_rdata | output | 32 | Read response data |

## Verification
The cycle outputs are registered once, so the bench drives each request for one clock and samples them at the falling edge after the next rising edge. The read response passes through a second register. It is sampled one clock later, and `tgt_rdata` is held steady across the cycle clock. Because the bench samples in exactly those two slots, a missing or extra pipeline stage shows up as a wrong value or a missing strobe. A latch write followed at once by a readback shows whether the latch update is visible one clock after the write.

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          io_req,
  input  logic [AW-3:0] io_addr,
  input  logic [3:0]    io_be,
  input  logic          io_wr,
  input  logic [31:0]   io_wdata,
  input  logic [7:0]    sec_bus,
  input  logic [7:0]    sub_bus,
  input  logic [31:0]   tgt_rdata,
  output logic          cyc_valid,
  output logic [1:0]    cyc_tgt,
  output logic          cyc_type1,
  output logic [7:0]    cyc_bus,
  output logic [4:0]    cyc_dev,
  output logic [2:0]    cyc_fn,
  output logic [5:0]    cyc_reg,
  output logic [3:0]    cyc_be,
  output logic          cyc_wr,
  output logic [31:0]   cyc_wdata,
  output logic          io_rvalid,
  output logic [31:0]   io_rdata
);
  localparam logic [AW-3:0] IDX_ADDR = (AW-2)'(16'h0CF8 >> 2);
  localparam logic [AW-3:0] IDX_DATA = (AW-2)'(16'h0CFC >> 2);
  localparam logic [1:0] TGT_INT = 2'd0, TGT_HUB = 2'd1, TGT_AGP = 2'd2;
  localparam logic [1:0] SRC_ADDR = 2'd0, SRC_TGT = 2'd1, SRC_ABORT = 2'd2;

  logic        en_q;
  logic [21:0] adr_q;
  logic        rd_pend;
  logic [1:0]  rd_src;
  logic [3:0]  rd_be;
  logic [31:0] rd_word;

  wire hit_a = io_req && (io_addr == IDX_ADDR);
  wire hit_d = io_req && (io_addr == IDX_DATA);
  wire [31:0] adr_word = {en_q, 7'b0, adr_q, 2'b00};
  wire [7:0]  bus = adr_q[21:14];
  wire [4:0]  dev = adr_q[13:9];

  logic [1:0] route_tgt;
  logic       route_t1;
  always_comb begin
    if (bus == 8'd0) begin
      route_t1  = 1'b0;
      route_tgt = (dev == 5'd0 || dev == 5'd1 || dev == 5'd6) ? TGT_INT : TGT_HUB;
    end else if (bus == sec_bus) begin
      route_t1  = 1'b0;
      route_tgt = TGT_AGP;
    end else if (bus > sec_bus && bus <= sub_bus) begin
      route_t1  = 1'b1;
      route_tgt = TGT_AGP;
    end else begin
      route_t1  = 1'b1;
      route_tgt = TGT_HUB;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      adr_q <= '0;
    end else if (hit_a && io_wr && io_be == 4'hF) begin
      en_q  <= io_wdata[31];
      adr_q <= io_wdata[23:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_valid <= 1'b0;
      cyc_tgt   <= '0;
      cyc_type1 <= 1'b0;
      cyc_bus   <= '0;
      cyc_dev   <= '0;
      cyc_fn    <= '0;
      cyc_reg   <= '0;
      cyc_be    <= '0;
      cyc_wr    <= 1'b0;
      cyc_wdata <= '0;
      rd_pend   <= 1'b0;
      rd_src    <= SRC_ADDR;
      rd_be     <= '0;
      rd_word   <= '0;
    end else begin
      cyc_valid <= hit_d && en_q;
      if (hit_d && en_q) begin
        cyc_tgt   <= route_tgt;
        cyc_type1 <= route_t1;
        cyc_bus   <= bus;
        cyc_dev   <= dev;
        cyc_fn    <= adr_q[8:6];
        cyc_reg   <= adr_q[5:0];
        cyc_be    <= io_be;
        cyc_wr    <= io_wr;
        cyc_wdata <= io_wdata;
      end
      rd_pend <= (hit_a || hit_d) && !io_wr;
      rd_src  <= hit_a ? SRC_ADDR : (en_q ? SRC_TGT : SRC_ABORT);
      rd_be   <= io_be;
      rd_word <= adr_word;
    end
  end

  logic [31:0] lane_mask, rd_sel;
  always_comb begin
    for (int i = 0; i < 4; i++) lane_mask[i*8 +: 8] = {8{rd_be[i]}};
    case (rd_src)
      SRC_ADDR: rd_sel = rd_word;
      SRC_TGT:  rd_sel = tgt_rdata;
      default:  rd_sel = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_pend;
      io_rdata  <= rd_pend ? (rd_sel & lane_mask) : '0;
    end
  end
endmodule

module cfg_cycle_router_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          io_req,
  input logic [AW-3:0] io_addr,
  input logic          io_wr,
  input logic          cyc_valid,
  input logic [1:0]    cyc_tgt,
  input logic          cyc_type1,
  input logic [7:0]    cyc_bus,
  input logic [4:0]    cyc_dev,
  input logic          io_rvalid
);
  localparam logic [AW-3:0] IDX_DATA = (AW-2)'(16'h0CFC >> 2);

  p_tgt_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> cyc_tgt != 2'd3);
  p_issue_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $past(io_req) && $past(io_addr) == IDX_DATA);
  p_internal_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_tgt == 2'd0) |->
      (cyc_bus == 8'd0 && !cyc_type1 && (cyc_dev == 5'd0 || cyc_dev == 5'd1 || cyc_dev == 5'd6)));
  p_bus0_type0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_bus == 8'd0) |-> !cyc_type1);
  p_agp_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_valid && cyc_tgt == 2'd2) |-> cyc_bus != 8'd0);
  p_rvalid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_req, 2) && !$past(io_wr, 2));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(io_req) |-> !cyc_valid);
endmodule

bind cfg_cycle_router cfg_cycle_router_chk #(.AW(AW)) chk_i (.*);

// File: tb/cfg_cycle_router_tb_top.sv
module cfg_cycle_router_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_req = 1'b0;
  logic [13:0] io_addr = '0;
  logic [3:0] io_be = '0;
  logic io_wr = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [7:0] sec_bus = 8'd2, sub_bus = 8'd5;
  logic [31:0] tgt_rdata = '0;
  logic cyc_valid, cyc_type1, cyc_wr, io_rvalid;
  logic [1:0] cyc_tgt;
  logic [7:0] cyc_bus;
  logic [4:0] cyc_dev;
  logic [2:0] cyc_fn;
  logic [5:0] cyc_reg;
  logic [3:0] cyc_be;
  logic [31:0] cyc_wdata, io_rdata;

  int total = 0, bad = 0;
  bit done = 0;

  localparam logic [13:0] IA = 14'h33E, ID = 14'h33F;

  cfg_cycle_router dut_i (.*);

  always #5 clk = ~clk;

  logic s_cv, s_t1, s_wr, s_rv;
  logic [1:0] s_tgt;
  logic [7:0] s_bus;
  logic [4:0] s_dev;
  logic [2:0] s_fn;
  logic [5:0] s_reg;
  logic [3:0] s_be;
  logic [31:0] s_wd, s_rd;

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic access(input logic [13:0] a, input logic [3:0] be, input logic wr, input logic [31:0] wd);
    @(negedge clk);
    io_req = 1'b1; io_addr = a; io_be = be; io_wr = wr; io_wdata = wd;
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0;
    s_cv = cyc_valid; s_tgt = cyc_tgt; s_t1 = cyc_type1; s_bus = cyc_bus; s_dev = cyc_dev;
    s_fn = cyc_fn; s_reg = cyc_reg; s_be = cyc_be; s_wr = cyc_wr; s_wd = cyc_wdata;
    @(negedge clk);
    s_rv = io_rvalid; s_rd = io_rdata;
  endtask

  function automatic logic [31:0] caddr(input logic en, input logic [7:0] b, input logic [4:0] d,
                                        input logic [2:0] f, input logic [5:0] r);
    return {en, 7'b0, b, d, f, r, 2'b00};
  endfunction

  task automatic t_reset;
    chk("R3", "cyc_valid after reset", 32'(cyc_valid), 0);
    chk("R9", "io_rvalid after reset", 32'(io_rvalid), 0);
    access(IA, 4'hF, 1'b0, 0);
    chk("R1", "latch reset value", s_rd, 0);
    chk("R9", "addr read rvalid", 32'(s_rv), 1);
  endtask

  task automatic t_latch;
    access(IA, 4'hF, 1'b1, 32'hFFAB_CDEF);
    access(IA, 4'hF, 1'b0, 0);
    chk("R1", "latch readback", s_rd, 32'h80AB_CDEC);
    access(IA, 4'h3, 1'b1, 32'h0);
    access(IA, 4'hF, 1'b0, 0);
    chk("R1", "partial write ignored", s_rd, 32'h80AB_CDEC);
    access(IA, 4'h6, 1'b0, 0);
    chk("R1", "masked latch read", s_rd, 32'h00AB_CD00);
  endtask

  task automatic t_disabled;
    access(IA, 4'hF, 1'b1, caddr(1'b0, 8'd0, 5'd0, 3'd0, 6'd4));
    access(ID, 4'hF, 1'b1, 32'h1234_5678);
    chk("R2", "no cycle when disabled", 32'(s_cv), 0);
    tgt_rdata = 32'h1111_1111;
    access(ID, 4'h5, 1'b0, 0);
    chk("R2", "disabled read lanes", s_rd, 32'h00FF_00FF);
    chk("R2", "disabled read rvalid", 32'(s_rv), 1);
  endtask

  task automatic route(input string req, input logic [7:0] b, input logic [4:0] d,
                       input logic [1:0] etgt, input logic et1);
    access(IA, 4'hF, 1'b1, caddr(1'b1, b, d, 3'd5, 6'h2A));
    access(ID, 4'hC, 1'b1, {b, 3'd0, d, 16'hA5A5});
    chk(req, "cyc_valid", 32'(s_cv), 1);
    chk(req, "target", 32'(s_tgt), 32'(etgt));
    chk(req, "type1", 32'(s_t1), 32'(et1));
    chk("R3", "fields", {s_bus, 3'd0, s_dev, 5'd0, s_fn, 2'd0, s_reg},
        {b, 3'd0, d, 5'd0, 3'd5, 2'd0, 6'h2A});
    chk("R3", "be/wr/wdata", {s_be, 3'd0, s_wr, s_wd[23:0]}, {4'hC, 3'd0, 1'b1, 3'd0, d, 16'hA5A5});
  endtask

  task automatic t_routes;
    route("R4", 8'd0, 5'd0, 2'd0, 1'b0);
    route("R4", 8'd0, 5'd1, 2'd0, 1'b0);
    route("R4", 8'd0, 5'd6, 2'd0, 1'b0);
    route("R5", 8'd0, 5'd3, 2'd1, 1'b0);
    route("R5", 8'd0, 5'd7, 2'd1, 1'b0);
    route("R6", 8'd2, 5'd4, 2'd2, 1'b0);
    route("R7", 8'd3, 5'd0, 2'd2, 1'b1);
    route("R7", 8'd5, 5'd9, 2'd2, 1'b1);
    route("R8", 8'd1, 5'd2, 2'd1, 1'b1);
    route("R8", 8'd6, 5'd2, 2'd1, 1'b1);
    route("R8", 8'd200, 5'd31, 2'd1, 1'b1);
  endtask

  task automatic t_read;
    access(IA, 4'hF, 1'b1, caddr(1'b1, 8'd0, 5'd1, 3'd0, 6'd0));
    tgt_rdata = 32'hDEAD_BEEF;
    access(ID, 4'hC, 1'b0, 0);
    chk("R9", "read rvalid", 32'(s_rv), 1);
    chk("R9", "read data masked", s_rd, 32'hDEAD_0000);
    chk("R3", "read cycle dir", {31'd0, s_wr}, 0);
    access(ID, 4'hF, 1'b1, 32'h0);
    chk("R9", "no rvalid on write", 32'(s_rv), 0);
  endtask

  task automatic t_ignore;
    access(14'h33D, 4'hF, 1'b1, 32'h0);
    chk("R10", "no cycle at other index", 32'(s_cv), 0);
    access(14'h020, 4'hF, 1'b0, 0);
    chk("R10", "no rvalid at other index", 32'(s_rv), 0);
    access(IA, 4'hF, 1'b0, 0);
    chk("R10", "latch unchanged", s_rd, caddr(1'b1, 8'd0, 5'd1, 3'd0, 6'd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_latch;
    t_disabled;
    t_routes;
    t_read;
    t_ignore;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule